// File: doc/BRIEF.md
# Q-Format Fractional Multiply Unit

This block multiplies two signed fixed-point fractions. Operand A is always a full 32-bit word. Operand B can be the whole word, its lower halfword, or its upper halfword, and either half is sign-extended to 32 bits. The signed 64-bit product is then scaled. A 32-bit destination takes a window of the product. A 64-bit destination takes the whole product, split across a low and a high output word. The fraction bit `n` adds one left shift of scaling, which gives the usual Q31 or Q15 alignment.

Every accepted operation also updates a set of status flags:

- an overflow flag that marks the one product that cannot be represented, -1 times -1 in fraction terms;
- an advance-overflow flag, taken from the two top bits of the delivered word;
- sticky copies of both flags, which accumulate until software clears them through `flag_clr`.

The result and the flags are registered and appear one clock after a valid strobe. Register-file access, decode and writeback are handled elsewhere.

Top module: `qmul_unit`

## Requirements
- R1: `op_sel[2:1]` selects operand B: 00 uses the full word `b`, 01 uses `b[15:0]` sign-extended, 10 uses `b[31:16]` sign-extended, and 11 is reserved. `op_sel[0]` selects the destination: 0 is a 32-bit result and 1 is a 64-bit result.
- R2: Full-word operand with a 32-bit result. With P the signed 64-bit product of `a` and the selected operand, `res_lo` is P[63:32] when n=0 and P[62:31] when n=1. `res_hi` is zero.
- R3: Halfword operand with a 32-bit result. `res_lo` is P[47:16] when n=0 and P[46:15] when n=1. `res_hi` is zero.
- R4: 64-bit result. {`res_hi`,`res_lo`} is P when n=0 and P shifted left by one when n=1.
- R5: `flag_v` is 0 after an operation with n=0. After an operation with n=1 it is 1 exactly when the delivered word equals 0x80000000; the delivered word is `res_hi` for 64-bit results and `res_lo` otherwise. The result is never saturated.
- R6: `flag_av` equals bit 31 XOR bit 30 of the delivered word.
- R7: `flag_sv` ORs in each new V value and `flag_sav` ORs in each new AV value. Both hold their value when no operation is accepted.
- R8: `flag_clr` clears `flag_sv` and `flag_sav` at the next clock edge. This takes priority over accumulation in the same cycle. `flag_clr` does not change `flag_v` or `flag_av`.
- R9: An accepted operation (`valid_in` high and a non-reserved select) raises `valid_out` and updates the result and flags one clock later. In other cycles `valid_out` is 0 and the results, V and AV hold their value.
- R10: A strobe with the reserved select 11 is ignored. `valid_out` stays 0 and every output keeps its value.
- R11: A synchronous active-low reset sets every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operation strobe |
| op_sel | input | 3 | [2:1] operand-B source, [0] 64-bit destination |
| n | input | 1 | Fraction shift bit |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B word |
| flag_clr | input | 1 | Synchronous clear of sticky flags |
| res_lo | output | 32 | Result word, or low word of a 64-bit result |
| res_hi | output | 32 | High word of a 64-bit result, zero otherwise |
| valid_out | output | 1 | Result valid, one cycle after strobe |
| flag_v | output | 1 | Overflow |
| flag_sv | output | 1 | Sticky overflow |
| flag_av | output | 1 | Advance overflow |
| flag_sav | output | 1 | Sticky advance overflow |

## Verification
The overflow flag rises only when both fractional operands are exactly -1 and n=1. For a halfword mode that means A = 0x80000000 with 0x8000 in the selected half of B. Uniform random operands almost never produce that pair. The stimulus therefore plants these exact operands in every operand-select and destination mode. It also biases the random operands toward them. Some of these overflow cases are followed by `flag_clr` to show that the sticky bits were set and then cleared.

// File: rtl/qmul_pkg.sv
// Package: shared encodings for the fractional multiply unit.
// Assumes op_sel[2:1] carries the operand-B source and op_sel[0] the width.
package qmul_pkg;

    localparam int OP_W = 3;

    typedef enum logic [1:0] {
        SRC_FULL = 2'b00,
        SRC_LO   = 2'b01,
        SRC_HI   = 2'b10,
        SRC_RSV  = 2'b11
    } src_e;

endpackage

// File: rtl/qmul_operand.sv
// Module: builds the effective second operand from the B word.
// Assumes DW is even; the halves are sign-extended to DW bits.
module qmul_operand
    import qmul_pkg::*;
#(
    parameter int DW = 32
) (
    input  src_e          src,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] b_eff,
    output logic          legal
);
    localparam int HW = DW / 2;

    // Purpose: pick the full word, or one sign-extended halfword.
    always_comb begin
        legal = 1'b1;
        unique case (src)
            SRC_FULL: b_eff = b;
            SRC_LO:   b_eff = {{HW{b[HW-1]}}, b[HW-1:0]};
            SRC_HI:   b_eff = {{HW{b[DW-1]}}, b[DW-1:HW]};
            default: begin
                b_eff = '0;
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qmul_core.sv
// Module: signed multiply with fractional scaling and flag generation.
// Purely combinational; assumes b_eff is already sign-extended to DW bits.
module qmul_core #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b_eff,
    input  logic          half,
    input  logic          wide,
    input  logic          n,
    output logic [DW-1:0] lo,
    output logic [DW-1:0] hi,
    output logic          v,
    output logic          av
);
    localparam int HW = DW / 2;
    localparam int PW = 2 * DW;
    localparam int SW = $clog2(DW + 1);
    localparam logic [DW-1:0] MIN_WORD = {1'b1, {(DW-1){1'b0}}};

    logic signed [PW-1:0] a_ext, b_ext, prod, scaled;
    logic [SW-1:0]        rshift;
    logic [DW-1:0]        word;

    // Purpose: full-width signed product of the two operands.
    always_comb begin
        a_ext = {{DW{a[DW-1]}}, a};
        b_ext = {{DW{b_eff[DW-1]}}, b_eff};
        prod  = a_ext * b_ext;
    end

    // Purpose: choose the product window for the destination width.
    always_comb begin
        if (half) rshift = SW'(HW) - SW'(n);
        else      rshift = SW'(DW) - SW'(n);
        if (wide) begin
            scaled = prod << n;
            lo     = scaled[DW-1:0];
            hi     = scaled[PW-1:DW];
        end else begin
            scaled = prod >>> rshift;
            lo     = scaled[DW-1:0];
            hi     = '0;
        end
    end

    // Purpose: overflow and advance-overflow from the delivered word.
    always_comb begin
        word = wide ? hi : lo;
        v    = n && (word == MIN_WORD);
        av   = word[DW-1] ^ word[DW-2];
    end
endmodule

// File: rtl/qmul_flags.sv
// Module: status flag registers with sticky accumulation.
// Assumes upd is high only in cycles that accept an operation.
module qmul_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic clr,
    input  logic v_in,
    input  logic av_in,
    output logic flag_v,
    output logic flag_sv,
    output logic flag_av,
    output logic flag_sav
);
    // Purpose: load V/AV per operation, OR them into the sticky copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_v   <= 1'b0;
            flag_av  <= 1'b0;
            flag_sv  <= 1'b0;
            flag_sav <= 1'b0;
        end else begin
            if (upd) begin
                flag_v  <= v_in;
                flag_av <= av_in;
            end
            if (clr) begin
                flag_sv  <= 1'b0;
                flag_sav <= 1'b0;
            end else if (upd) begin
                flag_sv  <= flag_sv | v_in;
                flag_sav <= flag_sav | av_in;
            end
        end
    end

    AST_SV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sv && !clr |=> flag_sv);                                  // R7
    AST_SAV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sav && !clr |=> flag_sav);                                // R7
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag_sv && !flag_sav);                                // R8
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flag_v) && $stable(flag_av));                 // R9
endmodule

// File: rtl/qmul_unit.sv
// Module: top of the fractional multiply unit; one register stage.
// Assumes the operands are stable in the strobe cycle; the result follows one clock later.
module qmul_unit
    import qmul_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_in,
    input  logic [2:0]    op_sel,
    input  logic          n,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          flag_clr,
    output logic [DW-1:0] res_lo,
    output logic [DW-1:0] res_hi,
    output logic          valid_out,
    output logic          flag_v,
    output logic          flag_sv,
    output logic          flag_av,
    output logic          flag_sav
);
    src_e          src;
    logic [DW-1:0] b_eff, lo_c, hi_c;
    logic          legal, accept, v_c, av_c;

    assign src    = src_e'(op_sel[2:1]);
    assign accept = valid_in && legal;

    qmul_operand #(.DW(DW)) i_operand (
        .src   (src),
        .b     (b),
        .b_eff (b_eff),
        .legal (legal)
    );

    qmul_core #(.DW(DW)) i_core (
        .a     (a),
        .b_eff (b_eff),
        .half  (src != SRC_FULL),
        .wide  (op_sel[0]),
        .n     (n),
        .lo    (lo_c),
        .hi    (hi_c),
        .v     (v_c),
        .av    (av_c)
    );

    qmul_flags i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (accept),
        .clr      (flag_clr),
        .v_in     (v_c),
        .av_in    (av_c),
        .flag_v   (flag_v),
        .flag_sv  (flag_sv),
        .flag_av  (flag_av),
        .flag_sav (flag_sav)
    );

    // Purpose: capture the result words and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo    <= '0;
            res_hi    <= '0;
            valid_out <= 1'b0;
        end else begin
            valid_out <= accept;
            if (accept) begin
                res_lo <= lo_c;
                res_hi <= hi_c;
            end
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> valid_out);                                         // R9
    AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && op_sel[2:1] == 2'b11 |=> !valid_out && $stable(res_lo) && $stable(res_hi)); // R10
    AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !op_sel[0] |=> res_hi == '0);                        // R2
    AST_V_CLEAR_N0: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !n |=> !flag_v);                                     // R5
endmodule

// File: tb/test_qmul_unit.sv
module test_qmul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        n = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] res_lo, res_hi;
    logic        valid_out, flag_v, flag_sv, flag_av, flag_sav;

    int checks = 0;
    int fails = 0;

    // expected state
    logic [31:0] e_lo = '0, e_hi = '0;
    logic        e_v = 0, e_sv = 0, e_av = 0, e_sav = 0, e_vo = 0;

    always #5 clk = ~clk;

    qmul_unit i_qmul_unit (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_sel(op_sel), .n(n),
        .a(a), .b(b), .flag_clr(flag_clr), .res_lo(res_lo), .res_hi(res_hi),
        .valid_out(valid_out), .flag_v(flag_v), .flag_sv(flag_sv),
        .flag_av(flag_av), .flag_sav(flag_sav)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference: the product is formed in the bench and its bits are sliced per requirement.
    function automatic logic [63:0] ref_result(input logic [2:0] op, input logic nn,
                                                input logic [31:0] x, input logic [31:0] y);
        logic signed [63:0] ye, p;
        case (op[2:1])
            2'b01:   ye = 64'(signed'(y[15:0]));
            2'b10:   ye = 64'(signed'(y[31:16]));
            default: ye = 64'(signed'(y));
        endcase
        p = 64'(signed'(x)) * ye;
        if (op[0])              return nn ? {p[62:0], 1'b0} : p;             // R4
        else if (op[2:1] == 0)  return {32'h0, nn ? p[62:31] : p[63:32]};    // R2
        else                    return {32'h0, nn ? p[46:15] : p[47:16]};    // R3
    endfunction

    // One clock: drive at the falling edge, check at the next falling edge.
    task automatic step(input logic vin, input logic [2:0] op, input logic nn,
                        input logic [31:0] x, input logic [31:0] y, input logic clr);
        logic [63:0] r;
        logic [31:0] w;
        logic        acc;
        string       rtag;
        valid_in = vin; op_sel = op; n = nn; a = x; b = y; flag_clr = clr;
        acc = vin && (op[2:1] != 2'b11);
        @(negedge clk);
        if (acc) begin
            r = ref_result(op, nn, x, y);
            e_lo = r[31:0];
            e_hi = r[63:32];
            w = op[0] ? e_hi : e_lo;
            e_v  = nn && (w == 32'h8000_0000);
            e_av = w[31] ^ w[30];
        end
        if (clr) begin
            e_sv = 0; e_sav = 0;
        end else if (acc) begin
            e_sv |= e_v; e_sav |= e_av;
        end
        e_vo = acc;
        rtag = !vin || !acc ? "R10" : op[0] ? "R4" : (op[2:1] == 0) ? "R2" : "R3";
        chk("R9", "valid_out", 64'(valid_out), 64'(e_vo));
        chk(rtag, "res_lo", 64'(res_lo), 64'(e_lo));
        chk(rtag, "res_hi", 64'(res_hi), 64'(e_hi));
        chk("R5", "flag_v", 64'(flag_v), 64'(e_v));
        chk("R6", "flag_av", 64'(flag_av), 64'(e_av));
        chk(clr ? "R8" : "R7", "flag_sv", 64'(flag_sv), 64'(e_sv));
        chk(clr ? "R8" : "R7", "flag_sav", 64'(flag_sav), 64'(e_sav));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "reset outputs", {res_lo, res_hi}, 64'h0);
        chk("R11", "reset flags", 64'({valid_out, flag_v, flag_sv, flag_av, flag_sav}), 64'h0);
        rst_n = 1'b1;

        // R1: operand-select modes with plain values
        step(1, 3'b000, 0, 32'h4000_0000, 32'h4000_0000, 0);
        step(1, 3'b010, 0, 32'h4000_0000, 32'hDEAD_4000, 0);
        step(1, 3'b100, 1, 32'h4000_0000, 32'h4000_BEEF, 0);
        step(1, 3'b011, 1, 32'h1234_5678, 32'h0000_9ABC, 0);
        step(1, 3'b101, 0, 32'hFEDC_BA98, 32'h8765_0000, 0);

        // R5: -1 x -1 in every mode with n=1, then n=0
        for (int m = 0; m < 6; m++) begin
            logic [2:0] op = 3'(m);
            logic [31:0] y = (op[2:1] == 2'b01) ? 32'h0000_8000 : 32'h8000_0000;
            step(1, op, 1, 32'h8000_0000, y, 0);
            step(1, op, 0, 32'h8000_0000, y, 0);
        end
        // R8: clear sticky flags, while accepting an overflow op
        step(1, 3'b001, 1, 32'h8000_0000, 32'h8000_0000, 1);
        step(0, 3'b000, 0, 32'h0, 32'h0, 0);
        step(0, 3'b000, 0, 32'h0, 32'h0, 1);
        // R10: reserved select ignored, with operands that would overflow
        step(1, 3'b110, 1, 32'h8000_0000, 32'h8000_0000, 0);
        step(1, 3'b111, 1, 32'h7FFF_FFFF, 32'h8000_0000, 0);
        // R9: idle cycles hold results
        step(0, 3'b001, 1, 32'h8000_0000, 32'h8000_0000, 0);

        // Random stimulus biased toward the minimum values
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  op;
            logic [31:0] x, y;
            int          sel = $urandom % 8;
            op = {2'($urandom % 3), 1'($urandom)};
            if (sel == 7) op = {2'b11, 1'($urandom)};
            x = ($urandom % 5 == 0) ? 32'h8000_0000 : $urandom;
            y = $urandom;
            if ($urandom % 5 == 0) y = 32'h8000_8000;
            step(($urandom % 6) != 0, op, 1'($urandom), x, y, ($urandom % 10) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule